// File: doc/BRIEF.md
# Light-Load Burst Sequencer

This block is the digital decision logic that moves a current-mode converter controller into and out of a low-power burst regime at light load. It watches four comparator flags taken from the feedback node and a slow timebase tick. When the feedback sits below its low threshold for a full qualification window, the block declares burst. In burst it gates the controller's bias and switching on and off inside a narrow hysteresis band, and it selects the reduced peak current limit.

Inside burst, a rising feedback above the wake level restarts switching, and a fall below the sleep level stops it again, so the feedback saws between the two levels. A feedback above the higher overload level means the load has come back. The block then drops out of burst at once and restores the full current limit. The qualification window counts timebase ticks. The count restarts whenever the low-feedback condition goes away, so only a continuous low period leads to burst.

The comparator flags are asynchronous to the block clock and are resynchronized before use. The tick and the undervoltage input are taken as synchronous.

Top module: `lowload_burst_ctrl`

## Requirements
- R1: After reset, and one clock after `uvlo_i` is seen high in any state, `burst_o`=0, `run_en_o`=1 and `ilim_low_o`=0.
- R2: Burst is declared only after `QUAL_TICKS` timebase ticks have arrived while the low flag is continuously high. With one tick fewer, `burst_o` stays 0.
- R3: A drop of the low flag during qualification discards the ticks counted so far. A new qualification then needs `QUAL_TICKS` fresh ticks.
- R4: On entering burst, `burst_o` goes to 1 and `run_en_o` goes to 0 (bias and switching off).
- R5: In burst with switching off, a high wake flag sets `run_en_o` to 1 while `burst_o` stays 1.
- R6: In burst with switching on, a high sleep flag sets `run_en_o` back to 0.
- R7: `ilim_low_o` is 1 (reduced limit) exactly while `burst_o` is 1, and 0 (full limit) otherwise.
- R8: In burst, a high overload flag returns the block to normal: `burst_o`=0, `run_en_o`=1, `ilim_low_o`=0.
- R9: Ticks that arrive while the low flag is 0 are not counted toward qualification.
- R10: Outside burst, the wake and sleep flags have no effect: `run_en_o` stays 1 and `burst_o` stays 0.
- R11: In burst with switching off, an overload flag takes priority over a simultaneous wake flag, and the block exits to normal.
- R12: A comparator flag change reaches the outputs on the third rising clock edge after it is applied (two synchronizer stages plus the state register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| uvlo_i | input | 1 | Synchronous undervoltage event; forces normal state |
| tick_i | input | 1 | One-cycle timebase pulse (millisecond scale) |
| fb_low_i | input | 1 | Feedback below the burst-entry threshold |
| fb_wake_i | input | 1 | Feedback above the wake level |
| fb_sleep_i | input | 1 | Feedback below the sleep level |
| fb_over_i | input | 1 | Feedback above the burst-exit level |
| burst_o | output | 1 | Burst mode flag |
| run_en_o | output | 1 | Bias and switching enable |
| ilim_low_o | output | 1 | Selects the reduced peak current limit |

## Verification
The hardest case to reach from the ports is a qualification that is interrupted one tick short of completion and then restarted. Only a design that truly clears the count tells these runs apart, because an accumulating count would finish early on the second attempt. The stimulus uses a shortened tick count and delivers ticks by hand. It gives exactly one tick fewer than needed, pulls the low flag away, reasserts it and gives the same short count again, and the burst flag must still be 0. A similar run feeds ticks while the low flag is 0, to show that ticks outside qualification are not counted.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL   = 2'd0,
    ST_QUALIFY  = 2'd1,
    ST_BURST_OFF = 2'd2,
    ST_BURST_ON = 2'd3
  } burst_state_t;

  localparam int FLAG_LOW   = 0;
  localparam int FLAG_WAKE  = 1;
  localparam int FLAG_SLEEP = 2;
  localparam int FLAG_OVER  = 3;
  localparam int NUM_FLAGS  = 4;
endpackage

// File: rtl/burst_flag_sync.sv
module burst_flag_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/burst_qual_timer.sv
module burst_qual_timer #(
  parameter int QUAL_TICKS = 20,
  localparam int CNT_W = $clog2(QUAL_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic tick_i,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(QUAL_TICKS);

  logic [CNT_W-1:0] count_q, count_d;
  logic             count_en;

  always_comb begin
    count_en = 1'b0;
    count_d  = count_q;
    if (!active_i) begin
      count_en = (count_q != '0);
      count_d  = '0;
    end else if (tick_i && (count_q != LIMIT)) begin
      count_en = 1'b1;
      count_d  = count_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign done_o = (count_q == LIMIT);

  // R2: the count never passes its limit
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= LIMIT);

  // R3: leaving qualification discards the ticks counted so far
  assert_count_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (count_q == '0));
endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
  import burst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic uvlo_i,
  input  logic low_i,
  input  logic wake_i,
  input  logic sleep_i,
  input  logic over_i,
  input  logic qual_done_i,
  output logic qual_active_o,
  output logic burst_o,
  output logic run_en_o,
  output logic ilim_low_o
);
  burst_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (uvlo_i) begin
      state_d = ST_NORMAL;
    end else begin
      unique case (state_q)
        ST_NORMAL:    if (low_i) state_d = ST_QUALIFY;
        ST_QUALIFY:   if (!low_i) state_d = ST_NORMAL;
                      else if (qual_done_i) state_d = ST_BURST_OFF;
        ST_BURST_OFF: if (over_i) state_d = ST_NORMAL;
                      else if (wake_i) state_d = ST_BURST_ON;
        ST_BURST_ON:  if (over_i) state_d = ST_NORMAL;
                      else if (sleep_i) state_d = ST_BURST_OFF;
        default:      state_d = ST_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_NORMAL;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    qual_active_o = (state_q == ST_QUALIFY);
    burst_o       = (state_q == ST_BURST_OFF) || (state_q == ST_BURST_ON);
    run_en_o      = (state_q != ST_BURST_OFF);
    ilim_low_o    = burst_o;
  end

  assert_uvlo_normal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |=> (state_q == ST_NORMAL));

  assert_no_early_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_QUALIFY && !qual_done_i) |=> (state_q != ST_BURST_OFF));

  assert_low_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_QUALIFY && !low_i && !uvlo_i) |=> (state_q == ST_NORMAL));

  assert_entry_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_o) |-> ($past(state_q) == ST_QUALIFY));

  assert_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BURST_OFF && wake_i && !over_i && !uvlo_i) |=> (state_q == ST_BURST_ON));

  assert_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BURST_ON && sleep_i && !over_i && !uvlo_i) |=> (state_q == ST_BURST_OFF));

  // R8 and R11: overload exit wins over wake and sleep
  assert_over_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_o && over_i) |=> (state_q == ST_NORMAL));

  assert_ignore_band_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_o && !(state_q == ST_QUALIFY && qual_done_i && low_i)) |=> !burst_o);
endmodule

// File: rtl/lowload_burst_ctrl.sv
module lowload_burst_ctrl
  import burst_pkg::*;
#(
  parameter int QUAL_TICKS  = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uvlo_i,
  input  logic tick_i,
  input  logic fb_low_i,
  input  logic fb_wake_i,
  input  logic fb_sleep_i,
  input  logic fb_over_i,
  output logic burst_o,
  output logic run_en_o,
  output logic ilim_low_o
);
  logic [NUM_FLAGS-1:0] flags_raw, flags_s;
  logic qual_active, qual_done;

  always_comb begin
    flags_raw             = '0;
    flags_raw[FLAG_LOW]   = fb_low_i;
    flags_raw[FLAG_WAKE]  = fb_wake_i;
    flags_raw[FLAG_SLEEP] = fb_sleep_i;
    flags_raw[FLAG_OVER]  = fb_over_i;
  end

  burst_flag_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(flags_raw), .sync_o(flags_s)
  );

  burst_qual_timer #(.QUAL_TICKS(QUAL_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .active_i(qual_active), .tick_i(tick_i),
    .done_o(qual_done)
  );

  burst_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo_i),
    .low_i(flags_s[FLAG_LOW]), .wake_i(flags_s[FLAG_WAKE]),
    .sleep_i(flags_s[FLAG_SLEEP]), .over_i(flags_s[FLAG_OVER]),
    .qual_done_i(qual_done), .qual_active_o(qual_active),
    .burst_o(burst_o), .run_en_o(run_en_o), .ilim_low_o(ilim_low_o)
  );

  assert_ilim_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_o) |-> $rose(ilim_low_o));
endmodule

// File: tb/lowload_burst_ctrl_test.sv
module lowload_burst_ctrl_test;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rst_n, uvlo, tick, low, wake, sleep, over;
  logic burst, run_en, ilim_low;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  lowload_burst_ctrl #(.QUAL_TICKS(N)) uut (
    .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo), .tick_i(tick),
    .fb_low_i(low), .fb_wake_i(wake), .fb_sleep_i(sleep), .fb_over_i(over),
    .burst_o(burst), .run_en_o(run_en), .ilim_low_o(ilim_low)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step(1); tick = 1'b0; step(1);
    end
  endtask

  task automatic enter_burst();
    low = 1'b1; step(4); give_ticks(N); step(3); low = 1'b0; step(3);
  endtask

  task automatic leave_burst();
    over = 1'b1; step(3); over = 1'b0; step(3);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; uvlo = 0; tick = 0; low = 0; wake = 0; sleep = 0; over = 0;
    step(4); rst_n = 1'b1; step(2);
    check("R1 reset burst", burst, 1'b0);
    check("R1 reset run_en", run_en, 1'b1);
    check("R7 reset ilim", ilim_low, 1'b0);
  endtask

  task automatic t_entry();
    low = 1'b1; step(4); give_ticks(N - 1); step(3);
    check("R2 short count", burst, 1'b0);
    give_ticks(1); step(2);
    check("R4 burst set", burst, 1'b1);
    check("R4 run off", run_en, 1'b0);
    check("R7 ilim low", ilim_low, 1'b1);
    low = 1'b0; step(3);
  endtask

  task automatic t_wake_sleep();
    wake = 1'b1; step(2);
    check("R12 not yet", run_en, 1'b0);
    step(1);
    check("R5 wake run", run_en, 1'b1);
    check("R5 still burst", burst, 1'b1);
    wake = 1'b0; sleep = 1'b1; step(3);
    check("R6 sleep off", run_en, 1'b0);
    sleep = 1'b0; step(2);
  endtask

  task automatic t_exit();
    over = 1'b1; step(3);
    check("R8 burst clear", burst, 1'b0);
    check("R8 run on", run_en, 1'b1);
    check("R8 ilim full", ilim_low, 1'b0);
    over = 1'b0; step(3);
  endtask

  task automatic t_restart();
    low = 1'b1; step(4); give_ticks(N - 1);
    low = 1'b0; step(4);
    low = 1'b1; step(4); give_ticks(N - 1); step(3);
    check("R3 restarted count", burst, 1'b0);
    give_ticks(1); step(2);
    check("R3 full count", burst, 1'b1);
    low = 1'b0; leave_burst();
  endtask

  task automatic t_tick_normal();
    give_ticks(N);
    low = 1'b1; step(4); give_ticks(N - 1); step(3);
    check("R9 normal ticks ignored", burst, 1'b0);
    low = 1'b0; step(4);
  endtask

  task automatic t_ignore();
    sleep = 1'b1; step(4);
    check("R10 sleep ignored", run_en, 1'b1);
    wake = 1'b1; step(4);
    check("R10 wake ignored", burst, 1'b0);
    sleep = 1'b0; wake = 1'b0; step(3);
  endtask

  task automatic t_priority();
    enter_burst();
    over = 1'b1; wake = 1'b1; step(3);
    check("R11 over wins", burst, 1'b0);
    check("R11 run on", run_en, 1'b1);
    over = 1'b0; wake = 1'b0; step(4);
    check("R11 stays normal", burst, 1'b0);
  endtask

  task automatic t_uvlo();
    enter_burst();
    check("R1 pre uvlo", burst, 1'b1);
    uvlo = 1'b1; step(1);
    check("R1 uvlo burst", burst, 1'b0);
    check("R1 uvlo run", run_en, 1'b1);
    uvlo = 1'b0; step(3);
  endtask

  initial begin
    t_reset();
    t_entry();
    t_wake_sleep();
    t_exit();
    t_restart();
    t_tick_normal();
    t_ignore();
    t_priority();
    t_uvlo();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule